// File: doc/BRIEF.md
# Serial Ring Pass-Through Node

This block is one slave on a ring of serial devices that all share a single serial clock. The master's data output feeds the first node, each node's serial output feeds the next, and the last node's output goes back to the master's data input. No per-node select is used. Every node holds a word-wide shift register between its serial input and its serial output. While the master is clocking, bits simply pass through this register. The node's locally visible received word and its pending reply are left untouched during that time.

A separate strobe marks the exchange point that all nodes share. The master clocks exactly one word per node, so that each node holds the word addressed to it, and then raises the strobe. On the strobe's rising edge, every node latches its register as the received word and loads its own reply. If local logic has not written a new reply since the last exchange, the node loads zero. A second run of the same number of word-times then carries all the replies back to the master. The node also counts bits. It reports a framing error when the strobe arrives part-way through a word.

All serial inputs are asynchronous to the node's system clock. They pass through two-flop synchronisers and are edge-detected there.

Top module: `ring_node`

## Requirements
- R1: A rising serial clock edge shifts the serial input into the register's least significant bit, and the register moves towards the MSB. The serial output presents the register's MSB, so a bit appears on the output 16 serial clocks after it entered.
- R2: The serial output changes only after a falling serial clock edge or at an exchange. It holds its value across rising edges.
- R3: Shifting leaves the received word unchanged. A local reply write leaves the shift register, and therefore the pass-through bit stream, unchanged.
- R4: On each rising edge of the exchange strobe, the received word takes the shift register contents. A valid pulse of exactly one system clock accompanies it.
- R5: At an exchange, the register loads the reply word if one is pending, and zero (0x0000) otherwise. The serial output then shows that word's MSB before any further serial clock.
- R6: A local write stores the reply word and sets the pending flag. An exchange clears the flag. A write in the same cycle as an exchange takes priority and leaves the flag set.
- R7: The bit count within a frame wraps every 16 bits and restarts at each exchange. The framing-error output pulses together with the valid pulse when the count at the strobe is not zero.
- R8: After reset, the received word, the serial output, the pending flag, the valid pulse and the framing error are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Shared serial clock; idles low |
| sdi_i | input | 1 | Serial data from the upstream node or the master |
| xchg_i | input | 1 | Exchange strobe; its rising edge triggers the swap |
| sdo_o | output | 1 | Serial data to the downstream node or the master |
| tx_we_i | input | 1 | Write strobe for the local reply word |
| tx_data_i | input | 16 | Local reply word |
| tx_pending_o | output | 1 | A reply has been written and not yet loaded |
| rx_data_o | output | 16 | Word captured at the last exchange |
| rx_valid_o | output | 1 | One-cycle pulse when rx_data_o updates |
| frame_err_o | output | 1 | One-cycle pulse when the strobe was not on a word boundary |

## Verification
The assertions take for granted that the serial clock and the exchange strobe never have edges within the same few system clocks. They also assume that every level on these inputs lasts at least three system clocks, so each synchronised edge is seen once and apart from the others. The bench therefore holds each half of the serial clock and each strobe level for eight system clocks. It changes serial data only while the serial clock is low, and raises the strobe only with the serial clock idle low. The bench drives all inputs on the falling system clock edge, so the synchronisers never see a change at their sampling edge.

// File: rtl/ring_node_pkg.sv
package ring_node_pkg;
  localparam int unsigned WORD_W_DEF = 16;
  localparam int unsigned SYNC_N_DEF = 2;
endpackage

// File: rtl/ring_sync.sv
module ring_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= async_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[k] <= '0;
      else         stg_q[k] <= stg_q[k-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/ring_bitcnt.sv
module ring_bitcnt #(
  parameter int unsigned WORD_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_i,
  input  logic load_i,
  output logic frame_err_o
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= load_i && (cnt_q != '0);
      if (load_i)               cnt_q <= '0;
      else if (shift_i)         cnt_q <= (cnt_q == CNT_MAX) ? '0 : cnt_q + 1'b1;
    end
  end

  assign frame_err_o = err_q;

  // counter never leaves the word range
  assert property (@(posedge clk_i) disable iff (!rst_ni) cnt_q <= CNT_MAX)
    else $error("assert_cnt_range_R7");
  // an exchange always restarts the count
  assert property (@(posedge clk_i) disable iff (!rst_ni) load_i |=> cnt_q == '0)
    else $error("assert_cnt_restart_R7");
endmodule

// File: rtl/ring_shift.sv
module ring_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              fall_i,
  input  logic              bit_i,
  input  logic              load_i,
  input  logic              tx_we_i,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic              sdo_o,
  output logic              tx_pending_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  logic [WORD_W-1:0] sreg_q, tx_q, rx_q, load_word;
  logic              sdo_q, pend_q, vld_q;

  assign load_word = pend_q ? tx_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      sdo_q  <= 1'b0;
      rx_q   <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= load_i;
      if (load_i) begin
        rx_q   <= sreg_q;
        sreg_q <= load_word;
        sdo_q  <= load_word[WORD_W-1];
      end else begin
        if (shift_i) sreg_q <= {sreg_q[WORD_W-2:0], bit_i};
        if (fall_i)  sdo_q  <= sreg_q[WORD_W-1];
      end
    end
  end

  // reply word holder; write wins over the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      pend_q <= 1'b0;
    end else if (tx_we_i) begin
      tx_q   <= tx_data_i;
      pend_q <= 1'b1;
    end else if (load_i) begin
      pend_q <= 1'b0;
    end
  end

  assign sdo_o        = sdo_q;
  assign tx_pending_o = pend_q;
  assign rx_data_o    = rx_q;
  assign rx_valid_o   = vld_q;

  assert property (@(posedge clk_i) disable iff (!rst_ni)
                   !$stable(sdo_q) |-> $past(fall_i || load_i))
    else $error("assert_sdo_timing_R2");
  assert property (@(posedge clk_i) disable iff (!rst_ni)
                   !vld_q |-> $stable(rx_q))
    else $error("assert_rx_hold_R3");
  assert property (@(posedge clk_i) disable iff (!rst_ni)
                   (load_i && !pend_q) |=> (sreg_q == '0))
    else $error("assert_load_zero_R5");
  assert property (@(posedge clk_i) disable iff (!rst_ni)
                   (load_i && !tx_we_i) |=> !pend_q)
    else $error("assert_pend_clear_R6");
endmodule

// File: rtl/ring_node.sv
module ring_node
  import ring_node_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned SYNC_N = SYNC_N_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              xchg_i,
  output logic              sdo_o,
  input  logic              tx_we_i,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic              tx_pending_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              frame_err_o
);
  logic [2:0] lvl;
  logic [1:0] prev_q;
  logic       shift, fall, load;

  ring_sync #(.W(3), .STAGES(SYNC_N)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({xchg_i, sdi_i, sclk_i}),
    .sync_o (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= {lvl[2], lvl[0]};
  end

  assign shift = lvl[0] & ~prev_q[0];
  assign fall  = ~lvl[0] & prev_q[0];
  assign load  = lvl[2] & ~prev_q[1];

  ring_shift #(.WORD_W(WORD_W)) i_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_i     (shift),
    .fall_i      (fall),
    .bit_i       (lvl[1]),
    .load_i      (load),
    .tx_we_i     (tx_we_i),
    .tx_data_i   (tx_data_i),
    .sdo_o       (sdo_o),
    .tx_pending_o(tx_pending_o),
    .rx_data_o   (rx_data_o),
    .rx_valid_o  (rx_valid_o)
  );

  ring_bitcnt #(.WORD_W(WORD_W)) i_bitcnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (shift),
    .load_i     (load),
    .frame_err_o(frame_err_o)
  );

  assert property (@(posedge clk_i) disable iff (!rst_ni) rx_valid_o |=> !rx_valid_o)
    else $error("assert_valid_pulse_R4");
  assert property (@(posedge clk_i) disable iff (!rst_ni) frame_err_o |-> rx_valid_o)
    else $error("assert_err_with_valid_R7");
  assert property (@(posedge clk_i) disable iff (!rst_ni) tx_we_i |=> tx_pending_o)
    else $error("assert_pend_set_R6");
endmodule

// File: tb/test_ring_node.sv
module test_ring_node;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, xchg = 1'b0, tx_we = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic sdo, tx_pending, rx_valid, frame_err;
  logic [W-1:0] rx_data;

  int n_chk = 0, n_bad = 0, n_valid = 0, n_err = 0, cyc = 0;
  bit finished = 0;

  // reference model state
  bit           mq[$];
  bit           m_pend = 0;
  logic [W-1:0] m_tx = '0, m_rx = '0;
  int           m_bits = 0;
  logic         m_sdo = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_node i_ring_node (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(sdi), .xchg_i(xchg),
    .sdo_o(sdo), .tx_we_i(tx_we), .tx_data_i(tx_data), .tx_pending_o(tx_pending),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .frame_err_o(frame_err)
  );

  always @(posedge clk) begin
    cyc++;
    if (rst_n && rx_valid)  n_valid++;
    if (rst_n && frame_err) n_err++;
  end

  // per-clock comparison of the held outputs against the model
  always @(negedge clk) begin
    if (rst_n && !finished && m_sdo !== 1'bx) begin
      if (rx_valid == 1'b0 && rx_data !== m_rx && !xchg) begin
        n_bad++; n_chk++;
        $display("FAIL R3 rx_data drift act=%h exp=%h", rx_data, m_rx);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pack_model();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[W-1-i] = mq[i];
    return v;
  endfunction

  task automatic set_model(input logic [W-1:0] v);
    mq.delete();
    for (int i = W-1; i >= 0; i--) mq.push_back(v[i]);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input bit b);
    @(negedge clk) sdi = b;
    wait_n(H);
    sclk = 1'b1;
    void'(mq.pop_front());
    mq.push_back(b);
    m_bits++;
    wait_n(H);
    check("R2 sdo held over rising edge", sdo, m_sdo);
    sclk = 1'b0;
    wait_n(H);
    m_sdo = mq[0];
    check("R1 sdo after falling edge", sdo, m_sdo);
  endtask

  task automatic shift_word(input logic [W-1:0] v, input int nbits);
    for (int i = nbits-1; i >= 0; i--) shift_bit(v[i]);
  endtask

  task automatic write_tx(input logic [W-1:0] v);
    @(negedge clk) begin tx_we = 1'b1; tx_data = v; end
    @(negedge clk) tx_we = 1'b0;
    m_pend = 1; m_tx = v;
    check("R6 pending after write", tx_pending, 1);
  endtask

  task automatic exchange();
    int v0, e0;
    bit exp_err;
    v0 = n_valid; e0 = n_err;
    exp_err = (m_bits % W) != 0;
    @(negedge clk) xchg = 1'b1;
    wait_n(H);
    m_rx = pack_model();
    set_model(m_pend ? m_tx : '0);
    m_pend = 0; m_bits = 0; m_sdo = mq[0];
    xchg = 1'b0;
    wait_n(H);
    check("R4 rx_data at exchange", rx_data, m_rx);
    check("R4 one valid pulse", n_valid - v0, 1);
    check("R7 framing error pulses", n_err - e0, exp_err);
    check("R5 sdo shows loaded MSB", sdo, m_sdo);
    check("R6 pending cleared", tx_pending, 0);
  endtask

  initial begin
    set_model('0);
    wait_n(4);
    check("R8 reset rx_data", rx_data, 0);
    check("R8 reset sdo", sdo, 0);
    check("R8 reset pending", tx_pending, 0);
    check("R8 reset valid/err", {rx_valid, frame_err}, 0);
    @(negedge clk) rst_n = 1'b1;
    wait_n(4);

    // R1 R3: pass-through with a reply written mid-frame
    shift_word(16'hA5C3 >> 8, 8);
    write_tx(16'h1234);
    shift_word(16'hA5C3, 8);
    check("R3 rx unchanged by shifting", rx_data, 0);
    exchange();

    // replies travel out while new data comes in
    shift_word(16'h0F0F, W);
    check("R3 rx held during frame", rx_data, 16'hA5C3);
    exchange();                                  // no write: R5 zero load
    shift_word(16'hFFFF, W);                     // outputs must be zeros
    write_tx(16'h8001);
    exchange();
    check("R5 loaded reply MSB one", sdo, 1);

    // R7 short frame, then a clean one
    shift_word(16'h0015, 5);
    exchange();
    shift_word(16'h3C5A, W);
    exchange();
    // R1 wrap: 32 bits in one frame is still on a boundary
    shift_word(16'hDEAD, W);
    shift_word(16'hBEEF, W);
    exchange();
    check("R1 last word of long frame", rx_data, 16'hBEEF);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=<100000 cycles", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule